// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a byte-addressed serial EEPROM on a two-wire bus. The storage array is an internal register array. The clock and data lines are brought into the system clock domain through a short synchronizer. The block recognises bus start and stop conditions and compares a device-select byte against three strap inputs. On a match it accepts a two-byte word address and then either collects write data into a one-page buffer or streams stored bytes back to the master.

The block never drives the data line high. It only asserts an open-drain pull-low enable, which the pad turns into a wired-AND with the rest of the bus. A stop that ends a write which carried at least one data byte commits the page buffer to the array. It then starts a modelled self-timed programming interval. During that interval the device ignores its own select byte. A write-protect input holds back the commit, and reads are unaffected by it.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop. A start at any point abandons the transfer in progress, releases the data line and begins a fresh device-select byte.
- R2: The device-select byte is, MSB first, the pattern 1010, then the three strap bits (strap_i[2] first), then a read flag as the LSB (1 = read). On a match the slave pulls the data line low for the ninth clock. On a mismatch it never pulls low, and it disregards every later byte until the next start, so no write is performed.
- R3: Bits move MSB first. Incoming bits are taken on the rising clock edge. The slave changes sda_oe only while the clock line is low, except for the release caused by a start or stop.
- R4: After each of the two word-address bytes and after each write data byte, the slave acknowledges on the ninth clock by setting sda_oe to 1 (1 = pull low).
- R5: A byte write that ends in a stop stores the byte at the addressed location, where a later read returns it.
- R6: During a write, the low five address bits step and wrap inside the current 32-byte page. A 33rd or later data byte overwrites the page from where it wrapped to.
- R7: A random read (write-select, two address bytes, repeated start, read-select) returns the addressed byte. Each master acknowledge returns the next byte, and the address rolls over from the last array location to location 0.
- R8: A stop that ends a write with at least one complete data byte, with wp_i low at the stop, starts a busy interval of exactly PROG_CYCLES system clocks. Nothing else starts one.
- R9: While the busy interval runs, the slave does not acknowledge its device-select byte.
- R10: With wp_i high at the stop, a write changes no stored byte and starts no busy interval. Reads work at either level of wp_i.
- R11: A master no-acknowledge followed by a stop ends a read. A following current-address read (read-select right after a start) continues at the location after the last byte sent.
- R12: After reset, sda_oe is 0 and no busy interval is active, so the first select byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release |
| strap_i | input | 3 | Device address straps |
| wp_i | input | 1 | Write protect, 1 = programming blocked |

## Verification
The hardest condition to reach from the ports is a page write that wraps. The bench starts a 34-byte write two bytes short of a page end, so the last two bytes land on the first two overwritten slots. It then reads the whole page back, in two halves. The second half uses a current-address read, so the read itself shows where the counter stood after the no-acknowledge. The busy window is reached by issuing a select byte straight after the committing stop, before the modelled programming time has passed.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int PAGE_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } bus_st_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rx_kind_t;

  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] s);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == s);
  endfunction

endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
  parameter int PG_W = 5,
  localparam int PB = 1 << PG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [PG_W-1:0] idx,
  input  logic [7:0]      wdata,
  output logic [PB*8-1:0] data_flat,
  output logic [PB-1:0]   mask
);

  for (genvar g = 0; g < PB; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr) begin
        vld_q <= 1'b0;
      end else if (we && (idx == PG_W'(g))) begin
        slot_q <= wdata;
        vld_q  <= 1'b1;
      end
    end
    assign data_flat[g*8 +: 8] = slot_q;
    assign mask[g]             = vld_q;
  end

endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
  parameter int AW   = 12,
  parameter int PG_W = 5,
  localparam int PB    = 1 << PG_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic               clk,
  input  logic [AW-1:0]      rd_addr,
  output logic [7:0]         rd_data,
  input  logic               commit,
  input  logic [AW-PG_W-1:0] commit_page,
  input  logic [PB*8-1:0]    buf_flat,
  input  logic [PB-1:0]      buf_mask
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PB; i++) begin
        if (buf_mask[i]) mem[{commit_page, i[PG_W-1:0]}] <= buf_flat[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee2w_prog_timer.sv
module ee2w_prog_timer #(
  parameter int CYCLES = 2000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= CW'(CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
  import ee2w_pkg::*;
#(
  parameter bit WIDE_ADDR   = 1'b0,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int AW   = WIDE_ADDR ? 13 : 12;
  localparam int PG_W = PAGE_W;
  localparam int PB   = 1 << PG_W;
  localparam int PN_W = AW - PG_W;

  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PG_W], a[PG_W-1:0] + 1'b1};
  endfunction

  function automatic logic [AW-1:0] array_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  // synchronized bus view and events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_t  st;
  rx_kind_t kind;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [7:0]    tx_sh;
  logic [AW-1:0] addr;
  logic          rd_q;
  logic          pend;
  logic          data_seen;

  logic [7:0] byte_in;
  logic [7:0] rd_data;
  logic       busy;

  // named internal events
  logic byte_done, dev_done, prog_go, buf_clr, buf_we;
  assign byte_in   = {sh[6:0], sda_s};
  assign byte_done = (st == ST_RX) && scl_rise && (cnt == 4'd7);
  assign dev_done  = byte_done && (kind == RX_DEV);
  assign prog_go   = stop_det && data_seen && !wp_i && !busy;
  assign buf_clr   = start_det || stop_det;
  assign buf_we    = byte_done && (kind == RX_DATA) && !start_det && !stop_det;

  logic [PB*8-1:0] buf_flat;
  logic [PB-1:0]   buf_mask;

  ee2w_page_buf #(.PG_W(PG_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .idx(addr[PG_W-1:0]), .wdata(byte_in),
    .data_flat(buf_flat), .mask(buf_mask)
  );

  ee2w_store #(.AW(AW), .PG_W(PG_W)) u_store (
    .clk(clk), .rd_addr(addr), .rd_data(rd_data),
    .commit(prog_go), .commit_page(addr[AW-1:PG_W]),
    .buf_flat(buf_flat), .buf_mask(buf_mask)
  );

  ee2w_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= RX_DEV;
      cnt       <= '0;
      sh        <= '0;
      tx_sh     <= '0;
      addr      <= '0;
      rd_q      <= 1'b0;
      pend      <= 1'b0;
      data_seen <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      st        <= ST_RX;
      kind      <= RX_DEV;
      cnt       <= '0;
      pend      <= 1'b0;
      data_seen <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      data_seen <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (scl_rise) begin
      unique case (st)
        ST_RX: begin
          sh  <= byte_in;
          cnt <= cnt + 1'b1;
          if (cnt == 4'd7) begin
            pend <= 1'b1;
            unique case (kind)
              RX_DEV: begin
                if (dev_hit(byte_in, strap_i) && !busy) rd_q <= byte_in[0];
                else begin
                  st   <= ST_SKIP;
                  pend <= 1'b0;
                end
              end
              RX_AHI:  addr[AW-1:8] <= byte_in[AW-9:0];
              RX_ALO:  addr[7:0]    <= byte_in;
              RX_DATA: begin
                addr      <= page_step(addr);
                data_seen <= 1'b1;
              end
            endcase
          end
        end
        ST_TX:   cnt <= cnt + 1'b1;
        ST_MACK: if (sda_s) st <= ST_SKIP;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (st)
        ST_RX: begin
          if (pend) begin
            pend   <= 1'b0;
            sda_oe <= 1'b1;
            st     <= ST_ACK;
            cnt    <= '0;
          end
        end
        ST_ACK: begin
          if (kind == RX_DEV && rd_q) begin
            tx_sh  <= rd_data;
            sda_oe <= ~rd_data[7];
            addr   <= array_step(addr);
            st     <= ST_TX;
            cnt    <= '0;
          end else begin
            sda_oe <= 1'b0;
            st     <= ST_RX;
            cnt    <= '0;
            unique case (kind)
              RX_DEV:  kind <= RX_AHI;
              RX_AHI:  kind <= RX_ALO;
              default: kind <= RX_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            st     <= ST_MACK;
            cnt    <= '0;
          end else begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end
        end
        ST_MACK: begin
          tx_sh  <= rd_data;
          sda_oe <= ~rd_data[7];
          addr   <= array_step(addr);
          st     <= ST_TX;
          cnt    <= '0;
        end
        default: ;
      endcase
    end
  end

  logic st_rx, st_skip;
  assign st_rx   = (st == ST_RX);
  assign st_skip = (st == ST_SKIP);

endmodule

// File: rtl/ee2w_checker.sv
module ee2w_checker #(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic busy,
  input logic dev_done,
  input logic st_rx,
  input logic st_skip,
  input logic wp_i
);

  int unsigned busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_rx && !sda_oe)); // R1

  AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R3

  AST_BUSY_NO_DEVACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> st_skip); // R9

  AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R8

  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES)); // R8

  AST_WP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R10

endmodule

bind eeprom_2w_slave ee2w_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .busy(busy), .dev_done(dev_done),
  .st_rx(st_rx), .st_skip(st_skip), .wp_i(wp_i)
);

// File: tb/sim_eeprom_2w_slave.sv
module sim_eeprom_2w_slave;

  localparam int Q     = 8;
  localparam int PROG  = 600;
  localparam int DEPTH = 4096;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = STRAP;
  logic sda_oe;
  logic sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  eeprom_2w_slave #(.WIDE_ADDR(1'b0), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [DEPTH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    put_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = !sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    m_sda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      d = {d[6:0], sda_line}; tick(Q);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda = nack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dsel(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  // write n bytes from addr; model follows page wrap when programming is allowed
  task automatic wr_seq(input logic [11:0] a, input int n, input logic [7:0] first,
                        input logic apply, input string req);
    logic ak;
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk({req, " R2 select ack"}, ak, 1);
    put_byte({4'h0, a[11:8]}, ak);   chk({req, " R4 addr hi ack"}, ak, 1);
    put_byte(a[7:0], ak);            chk({req, " R4 addr lo ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      put_byte(first + 8'(k), ak);   chk({req, " R4 data ack"}, ak, 1);
      if (apply) model[{a[11:5], 5'((a[4:0] + k) % 32)}] = first + 8'(k);
    end
    send_stop();
  endtask

  task automatic rd_rand(input logic [11:0] a, input int n, input string req);
    logic ak;
    logic [7:0] d;
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk({req, " R7 select ack"}, ak, 1);
    put_byte({4'h0, a[11:8]}, ak);   chk({req, " R7 addr hi ack"}, ak, 1);
    put_byte(a[7:0], ak);            chk({req, " R7 addr lo ack"}, ak, 1);
    send_start();
    put_byte(dsel(STRAP, 1'b1), ak); chk({req, " R7 read select ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k == n - 1, d);
      chk({req, " R7 read data"}, d, model[12'(a + k)]);
    end
    send_stop();
  endtask

  task automatic busy_probe(input string req);
    logic ak;
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk({req, " R9 no ack while busy"}, ak, 0);
    send_stop();
    tick(PROG + 50);
  endtask

  task automatic t_reset();
    chk("R12 sda_oe low after reset", sda_oe, 0);
    chk("R12 line released after reset", sda_line, 1);
  endtask

  task automatic t_byte_write();
    wr_seq(12'h123, 1, 8'h5A, 1'b1, "byte write R5");
    busy_probe("byte write R8");
    rd_rand(12'h123, 1, "byte readback R5");
  endtask

  task automatic t_page_wrap();
    logic ak;
    logic [7:0] d;
    wr_seq(12'h25E, 34, 8'h40, 1'b1, "page wrap R6");
    busy_probe("page wrap R8");
    rd_rand(12'h240, 16, "page wrap R6 first half");
    send_start();
    put_byte(dsel(STRAP, 1'b1), ak); chk("R11 current read select ack", ak, 1);
    for (int k = 16; k < 32; k++) begin
      get_byte(k == 31, d);
      chk("R11 R6 current read data", d, model[12'h240 + k]);
    end
    send_stop();
  endtask

  task automatic t_mismatch();
    logic ak;
    send_start();
    put_byte(dsel(3'b001, 1'b0), ak); chk("R2 wrong strap not acked", ak, 0);
    put_byte(8'h01, ak);              chk("R2 ignored byte not acked", ak, 0);
    put_byte(8'h23, ak);
    put_byte(8'h77, ak);
    send_stop();
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak);  chk("R2 no programming after mismatch", ak, 1);
    send_stop();
    rd_rand(12'h123, 1, "R2 data kept after mismatch");
  endtask

  task automatic t_write_protect();
    logic ak;
    wp = 1'b1;
    wr_seq(12'h123, 1, 8'h99, 1'b0, "R10 protected write");
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk("R10 no busy after protected write", ak, 1);
    send_stop();
    rd_rand(12'h123, 1, "R10 read with wp high");
    wp = 1'b0;
  endtask

  task automatic t_rollover();
    wr_seq(12'hFFF, 1, 8'hAB, 1'b1, "R7 last location");
    tick(PROG + 50);
    wr_seq(12'h000, 1, 8'hCD, 1'b1, "R7 first location");
    tick(PROG + 50);
    rd_rand(12'hFFF, 2, "R7 rollover read");
  endtask

  task automatic t_start_abort();
    logic ak;
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak);
    put_byte(8'h01, ak);
    put_byte(8'h23, ak);
    put_bits(8'hF0, 4);
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk("R1 select acked after mid-byte start", ak, 1);
    send_stop();
    send_start();
    put_byte(dsel(STRAP, 1'b0), ak); chk("R1 R8 partial byte starts no busy", ak, 1);
    send_stop();
    rd_rand(12'h123, 1, "R1 data kept after abort");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_mismatch();
    t_write_protect();
    t_rollover();
    t_start_abort();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule